// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit device address into a physical address by walking a two-level translation table held in memory. A client hands it one address at a time over a valid/ready request channel. The block first reads a first-level descriptor, chosen by the top address bits and the table root. That descriptor can end the walk as a 1 MB or 16 MB mapping, or it can point at a second-level table. In the second case the block reads one more descriptor, which maps a 4 KB or 64 KB page. The result is returned on a valid/ready response channel as either a physical address or a translation fault. The response always carries the device address that was translated.

Memory is reached through a read-only port. The block raises a request with an address and holds it. The memory answers after any number of cycles with a one-cycle acknowledge that carries the data. Mappings of 16 MB and 64 KB are stored in the tables as sixteen identical descriptors in consecutive slots. The walker needs no special handling for this: whichever replica it reads gives the same result. Only one walk is in progress at any time.

Top module: `twl_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: The first fetch of a walk reads address {`root_base`[31:14], address[31:20], 2'b00}. A request is accepted only in a cycle where `req_valid` and `req_ready` are both 1.
- R3: The type of a first-level descriptor is its bits [1:0]. Type 2'b00, including an all-zero descriptor, gives a fault response after exactly one fetch, with no second-level fetch.
- R4: First-level type 2'b10 is a 1 MB mapping. The physical address is {descriptor[31:20], address[19:0]}, the walk makes one fetch, and the lower descriptor bits are ignored.
- R5: First-level type 2'b11 is a 16 MB mapping, giving {descriptor[31:24], address[23:0]}. Every address covered by the 16 replicated slots translates into the same 16 MB region.
- R6: First-level type 2'b01 points to a second-level table. The second fetch reads {descriptor[31:10], address[19:12], 2'b00}, and descriptor bits [9:2] are ignored.
- R7: Second-level type 2'b10 is a 4 KB page, giving {descriptor[31:12], address[11:0]}.
- R8: Second-level type 2'b01 is a 64 KB page, giving {descriptor[31:16], address[15:0]}. Its 16 replicated slots all give the same region.
- R9: Second-level types 2'b00 and 2'b11 give a fault. On every fault `rsp_fault` is 1, `rsp_pa` is 0 and `rsp_addr` equals the requested address.
- R10: From the accepting edge until the response has been taken, `req_ready` stays 0. While `rsp_ready` is 0, the response stays valid and does not change.
- R11: `mem_req` stays asserted with a stable `mem_addr` until `mem_ack`. Any acknowledge latency, including one cycle, gives a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | First-level table base, 16 KB aligned |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_addr | input | 32 | Device address to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Client takes the result |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| rsp_addr | output | 32 | Device address this result belongs to |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ack | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Descriptor word |

## Verification
Some protocol rules are checked on every cycle. The response must stay stable under backpressure, the block must accept no new request while a walk is open, and a memory request must stay held until it is acknowledged. The first-fetch index must follow the accepted address, and a fault must always return a zero physical address. The rest can only be shown by the bench's scenarios, because the result depends on table contents. These are the decode of each descriptor type, the masking of ignored descriptor bits, the second-level fetch address, the agreement across replicated slots, and the absence of a second fetch after a first-level fault.

// File: rtl/twl_pkg.sv
package twl_pkg;
   typedef enum logic [2:0] {
      K_FAULT   = 3'd0,
      K_TABLE   = 3'd1,
      K_SECTION = 3'd2,
      K_SUPER   = 3'd3,
      K_SMALL   = 3'd4,
      K_LARGE   = 3'd5
   } desc_kind_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_FETCH1 = 2'd1,
      S_FETCH2 = 2'd2,
      S_RESP  = 2'd3
   } walk_state_e;

   localparam int unsigned TYPE_W   = 2;
   localparam int unsigned REPL_LOG = 4;  // 16 replicated slots
endpackage

// File: rtl/twl_desc_decode.sv
module twl_desc_decode
   import twl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned L1_BITS = 12,
   parameter int unsigned L2_BITS = 8,
   parameter int unsigned LEVEL   = 1
) (
   input  logic [ADDR_W-1:0] desc,
   input  logic [ADDR_W-1:0] va,
   output desc_kind_e        kind,
   output logic [ADDR_W-1:0] pa
);
   localparam int unsigned SEC_SH   = ADDR_W - L1_BITS;
   localparam int unsigned PAGE_SH  = SEC_SH - L2_BITS;
   localparam int unsigned SUPER_SH = SEC_SH + REPL_LOG;
   localparam int unsigned LARGE_SH = PAGE_SH + REPL_LOG;
   localparam logic [ADDR_W-1:0] ONES = '1;

   logic [ADDR_W-1:0] keep_mask;

   generate
      if (LEVEL == 1) begin : g_first
         always_comb begin
            keep_mask = '0;
            case (desc[TYPE_W-1:0])
               2'b01:   kind = K_TABLE;
               2'b10: begin
                  kind      = K_SECTION;
                  keep_mask = ONES << SEC_SH;
               end
               2'b11: begin
                  kind      = K_SUPER;
                  keep_mask = ONES << SUPER_SH;
               end
               default: kind = K_FAULT;
            endcase
         end
      end else begin : g_second
         always_comb begin
            keep_mask = '0;
            case (desc[TYPE_W-1:0])
               2'b10: begin
                  kind      = K_SMALL;
                  keep_mask = ONES << PAGE_SH;
               end
               2'b01: begin
                  kind      = K_LARGE;
                  keep_mask = ONES << LARGE_SH;
               end
               default: kind = K_FAULT;
            endcase
         end
      end
   endgenerate

   always_comb begin
      if (keep_mask == '0) pa = '0;
      else                 pa = (desc & keep_mask) | (va & ~keep_mask);
   end
endmodule

// File: rtl/twl_addr_gen.sv
module twl_addr_gen #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned L1_BITS = 12,
   parameter int unsigned L2_BITS = 8,
   parameter int unsigned DESC_LG = 2
) (
   input  logic [ADDR_W-1:0]                 root_base,
   input  logic [ADDR_W-1:0]                 va,
   input  logic [ADDR_W-L2_BITS-DESC_LG-1:0] tbl_base,
   input  logic                              second,
   output logic [ADDR_W-1:0]                 mem_addr
);
   localparam int unsigned ROOT_SH = L1_BITS + DESC_LG;
   localparam int unsigned SEC_SH  = ADDR_W - L1_BITS;
   localparam int unsigned PAGE_SH = SEC_SH - L2_BITS;

   logic [ADDR_W-1:0] first_addr;
   logic [ADDR_W-1:0] second_addr;

   assign first_addr  = {root_base[ADDR_W-1:ROOT_SH], va[ADDR_W-1:SEC_SH],
                         {DESC_LG{1'b0}}};
   assign second_addr = {tbl_base, va[SEC_SH-1:PAGE_SH], {DESC_LG{1'b0}}};
   assign mem_addr    = second ? second_addr : first_addr;
endmodule

// File: rtl/twl_ctrl.sv
module twl_ctrl
   import twl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned TBL_W   = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              rsp_ready,
   input  logic              mem_ack,
   input  logic [TBL_W-1:0]  ack_tbl,
   input  desc_kind_e        kind1,
   input  logic [ADDR_W-1:0] pa1,
   input  desc_kind_e        kind2,
   input  logic [ADDR_W-1:0] pa2,
   output walk_state_e       state,
   output logic [ADDR_W-1:0] va_q,
   output logic [TBL_W-1:0]  tbl_q,
   output logic [ADDR_W-1:0] pa_q,
   output logic              fault_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         va_q    <= '0;
         tbl_q   <= '0;
         pa_q    <= '0;
         fault_q <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (req_valid) begin
               va_q  <= req_addr;
               state <= S_FETCH1;
            end
            S_FETCH1: if (mem_ack) begin
               case (kind1)
                  K_TABLE: begin
                     tbl_q <= ack_tbl;
                     state <= S_FETCH2;
                  end
                  K_SECTION, K_SUPER: begin
                     pa_q    <= pa1;
                     fault_q <= 1'b0;
                     state   <= S_RESP;
                  end
                  default: begin
                     pa_q    <= '0;
                     fault_q <= 1'b1;
                     state   <= S_RESP;
                  end
               endcase
            end
            S_FETCH2: if (mem_ack) begin
               if (kind2 == K_SMALL || kind2 == K_LARGE) begin
                  pa_q    <= pa2;
                  fault_q <= 1'b0;
               end else begin
                  pa_q    <= '0;
                  fault_q <= 1'b1;
               end
               state <= S_RESP;
            end
            default: if (rsp_ready) state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/twl_top.sv
module twl_top
   import twl_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned L1_BITS = 12,
   parameter int unsigned L2_BITS = 8,
   parameter int unsigned DESC_LG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] root_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_pa,
   output logic              rsp_fault,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata
);
   localparam int unsigned TBL_SH = L2_BITS + DESC_LG;
   localparam int unsigned TBL_W  = ADDR_W - TBL_SH;

   if (ADDR_W - L1_BITS - L2_BITS < REPL_LOG + DESC_LG) begin : g_bad_split
      $error("page offset too narrow for replicated descriptors");
   end
   if (L1_BITS < REPL_LOG || L2_BITS < REPL_LOG) begin : g_bad_index
      $error("table index narrower than replication group");
   end
   if (DESC_LG < TYPE_W) begin : g_bad_desc
      $error("descriptor alignment leaves no room for type bits");
   end

   walk_state_e       state;
   logic [ADDR_W-1:0] va_q;
   logic [TBL_W-1:0]  tbl_q;
   logic [ADDR_W-1:0] pa_q;
   logic              fault_q;
   desc_kind_e        kind1, kind2;
   logic [ADDR_W-1:0] pa1, pa2;

   twl_desc_decode #(.ADDR_W(ADDR_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
                     .LEVEL(1)) u_dec1 (
      .desc(mem_rdata), .va(va_q), .kind(kind1), .pa(pa1));

   twl_desc_decode #(.ADDR_W(ADDR_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
                     .LEVEL(2)) u_dec2 (
      .desc(mem_rdata), .va(va_q), .kind(kind2), .pa(pa2));

   twl_addr_gen #(.ADDR_W(ADDR_W), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
                  .DESC_LG(DESC_LG)) u_agen (
      .root_base(root_base), .va(va_q), .tbl_base(tbl_q),
      .second(state == S_FETCH2), .mem_addr(mem_addr));

   twl_ctrl #(.ADDR_W(ADDR_W), .TBL_W(TBL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_ready(rsp_ready), .mem_ack(mem_ack),
      .ack_tbl(mem_rdata[ADDR_W-1:TBL_SH]),
      .kind1(kind1), .pa1(pa1), .kind2(kind2), .pa2(pa2),
      .state(state), .va_q(va_q), .tbl_q(tbl_q), .pa_q(pa_q),
      .fault_q(fault_q));

   assign req_ready = (state == S_IDLE);
   assign mem_req   = (state == S_FETCH1) || (state == S_FETCH2);
   assign rsp_valid = (state == S_RESP);
   assign rsp_pa    = pa_q;
   assign rsp_fault = fault_q;
   assign rsp_addr  = va_q;
endmodule

// File: rtl/twl_chk.sv
module twl_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned L1_BITS = 12,
   parameter int unsigned DESC_LG = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] root_base,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [ADDR_W-1:0] rsp_pa,
   input logic              rsp_fault,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack
);
   localparam int unsigned IDX_HI = L1_BITS + DESC_LG - 1;

   // R10: no acceptance while a result is pending
   p_busy_while_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R10: result held under backpressure
   p_resp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa)
                                     && $stable(rsp_fault) && $stable(rsp_addr)));

   // R11: memory request held until acknowledged
   p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R10: idle walker issues no reads
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);

   // R2: first fetch indexes by the accepted address
   p_first_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_req
         && mem_addr[IDX_HI:DESC_LG] == $past(req_addr[ADDR_W-1:ADDR_W-L1_BITS])
         && mem_addr[ADDR_W-1:IDX_HI+1] == $past(root_base[ADDR_W-1:IDX_HI+1])));

   // R9: faults carry a zero physical address
   p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0));
endmodule

bind twl_top twl_chk #(.ADDR_W(ADDR_W), .L1_BITS(L1_BITS), .DESC_LG(DESC_LG)) u_chk (
   .clk(clk), .rst_n(rst_n), .root_base(root_base), .req_valid(req_valid),
   .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
   .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
   .rsp_addr(rsp_addr), .mem_req(mem_req), .mem_addr(mem_addr),
   .mem_ack(mem_ack));

// File: tb/twl_top_tb_top.sv
module twl_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] root_base = 32'h0008_0000;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_pa;
   logic        rsp_fault;
   logic [31:0] rsp_addr;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack;
   logic [31:0] mem_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   twl_top dut_i (
      .clk(clk), .rst_n(rst_n), .root_base(root_base), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
      .rsp_addr(rsp_addr), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   // memory model with adjustable latency
   logic [31:0] mem [logic [31:0]];
   int          lat_cfg = 0;
   int          wait_c = 0;
   int          nfetch = 0;
   logic [31:0] flog [0:3];

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_rdata <= '0;
         wait_c <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (wait_c >= lat_cfg) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            if (nfetch < 4) flog[nfetch] <= mem_addr;
            nfetch    <= nfetch + 1;
            wait_c    <= 0;
         end else begin
            wait_c <= wait_c + 1;
         end
      end
   end

   function automatic logic [31:0] l1a(input logic [31:0] va);
      return {root_base[31:14], va[31:20], 2'b00};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   logic [31:0] got_pa, got_addr;
   logic        got_fault;

   task automatic walk(input logic [31:0] va, input int hold);
      @(negedge clk);
      nfetch = 0;
      req_addr  = va;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      for (int i = 0; i < hold; i++) @(negedge clk);
      got_pa    = rsp_pa;
      got_fault = rsp_fault;
      got_addr  = rsp_addr;
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
      chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
   endtask

   task automatic t_section;
      lat_cfg = 0;
      walk(32'h1234_5678, 0);
      chk("R4 pa", got_pa, 32'h8AB4_5678);
      chk("R4 fault", {31'd0, got_fault}, 32'd0);
      chk("R4 fetches", nfetch, 1);
      chk("R2 l1 address", flog[0], l1a(32'h1234_5678));
   endtask

   task automatic t_super;
      lat_cfg = 2;
      walk(32'h4012_3456, 0);
      chk("R5 pa first", got_pa, 32'hC512_3456);
      walk(32'h40F0_0ABC, 0);
      chk("R5 pa last replica", got_pa, 32'hC5F0_0ABC);
      chk("R5 fault", {31'd0, got_fault}, 32'd0);
   endtask

   task automatic t_small;
      lat_cfg = 3;
      walk(32'h0030_5ABC, 0);
      chk("R7 pa", got_pa, 32'h7777_7ABC);
      chk("R6 fetches", nfetch, 2);
      chk("R6 l2 address", flog[1], 32'h0009_0414);
      chk("R11 slow memory fault", {31'd0, got_fault}, 32'd0);
   endtask

   task automatic t_large;
      lat_cfg = 1;
      walk(32'h0034_9876, 0);
      chk("R8 pa", got_pa, 32'h6543_9876);
      walk(32'h0034_F001, 0);
      chk("R8 pa last replica", got_pa, 32'h6543_F001);
   endtask

   task automatic t_l1_fault;
      lat_cfg = 0;
      walk(32'h0990_0000, 0);
      chk("R3 fault zero desc", {31'd0, got_fault}, 32'd1);
      chk("R3 single fetch", nfetch, 1);
      chk("R9 addr", got_addr, 32'h0990_0000);
      chk("R9 pa zero", got_pa, 32'h0);
      walk(32'h0A00_0123, 0);
      chk("R3 fault type00", {31'd0, got_fault}, 32'd1);
      chk("R3 single fetch type00", nfetch, 1);
   endtask

   task automatic t_l2_fault;
      lat_cfg = 4;
      walk(32'h0031_0000, 0);
      chk("R9 type00 fault", {31'd0, got_fault}, 32'd1);
      chk("R9 type00 fetches", nfetch, 2);
      walk(32'h0031_1ABC, 0);
      chk("R9 type11 fault", {31'd0, got_fault}, 32'd1);
      chk("R9 type11 addr", got_addr, 32'h0031_1ABC);
      chk("R9 type11 pa", got_pa, 32'h0);
   endtask

   task automatic t_backpressure;
      logic [31:0] pa0;
      lat_cfg = 0;
      @(negedge clk);
      nfetch = 0;
      req_addr = 32'h1234_0001;
      req_valid = 1'b1;
      @(negedge clk);
      req_addr = 32'h4000_0000;  // another request stays pending
      while (!rsp_valid) @(negedge clk);
      pa0 = rsp_pa;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R10 ready low", {31'd0, req_ready}, 32'd0);
         chk("R10 pa stable", rsp_pa, pa0);
      end
      chk("R10 no extra fetch", nfetch, 1);
      chk("R10 pa value", pa0, 32'h8AB4_0001);
      rsp_ready = 1'b1;
      req_valid = 1'b0;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R10 ready again", {31'd0, req_ready}, 32'd1);
   endtask

   initial begin
      mem[l1a(32'h1234_5678)] = 32'h8ABF_FFF2;
      for (int i = 0; i < 16; i++)
         mem[l1a(32'h4000_0000 + (i << 20))] = 32'hC5FF_FFF3;
      mem[l1a(32'h0030_0000)] = 32'h0009_07FD;
      mem[l1a(32'h0031_0000)] = 32'h0009_07FD;
      mem[l1a(32'h0034_0000)] = 32'h0009_07FD;
      mem[l1a(32'h0A00_0000)] = 32'h1234_5000;
      mem[32'h0009_0414] = 32'h7777_7FFE;
      mem[32'h0009_0440] = 32'h1234_5600;
      mem[32'h0009_0444] = 32'hFFFF_FFFF;
      for (int i = 0; i < 16; i++)
         mem[32'h0009_0500 + (i << 2)] = 32'h6543_FFF5;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_section();
      t_super();
      t_small();
      t_large();
      t_l1_fault();
      t_l2_fault();
      t_backpressure();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule